// File: doc/BRIEF.md
# GOP Frame-Type Sequencer

This block tells a video encoder which picture type to use for each incoming frame, in display order. A frame-start strobe advances the sequence. One cycle later the block returns a two-bit picture-type code and a marker that shows whether the frame opens a new group of pictures.

The group length, the number of B pictures between anchors, the group mode and a periodic key-frame distance come from configuration inputs. The block checks these inputs against a divisibility rule and reports any combination it cannot honour. The modes are:

- the classic I-B-B-P pattern;
- the same pattern with every P anchor turned into B;
- low-delay P, where an I picture is followed only by P pictures;
- low-delay B, where an I picture is followed only by B pictures.

An external key-frame request forces an IDR picture and restarts the group. A request that arrives between frames waits for the next frame.

Top module: `gop_type_seq`

## Requirements
- R1: Each cycle with `frame_start` high produces `ftype_valid` high in the following cycle only, together with `ftype` and `gop_start`. In cycles with no such strobe, `ftype_valid` and `gop_start` are low, including right after reset. The codes are IDR=0, I=1, P=2, B=3.
- R2: The first frame after reset is IDR with `gop_start` high.
- R3: With a group length of 0 or 1, every frame has `gop_start` high. Its type is I, unless an IDR cause applies.
- R4: Mode 0 (I-B-P) works on the frame at position p of a group, counted from 0 up to length-1:
  - p=0 is I, or IDR when a key frame is due;
  - any other p is P when p mod (B count + 1) is 0, and B otherwise;
  - after the last position a new group starts.
- R5: The other modes give these types for every non-opening frame of a group:
  - mode 1 gives B;
  - mode 2 gives P;
  - mode 3 gives B.
- R6: `cfg_invalid` is high, combinationally, in any of these cases:
  - the B count is above 4;
  - the group length is above 1000;
  - the IDR period is above 1000;
  - the group length is at least 2 and is not a multiple of (B count + 1).

  While `cfg_invalid` is high, a group start keeps the previously active configuration.
- R7: A configuration change that arrives mid-group has no effect until the next frame with `gop_start` high. From that frame on, the new configuration applies.
- R8: A nonzero IDR period N makes the frame N frames after the previous IDR an IDR, and that frame restarts the group. A period of 0 turns periodic IDR off.
- R9: `idr_req` high in the same cycle as `frame_start` makes that frame IDR. The group restarts at that frame.
- R10: `idr_req` pulses that arrive between frames are held, and they give no output. The next frame is IDR. Any number of such pulses yields a single IDR: the frame after it is not IDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe per incoming frame |
| idr_req | input | 1 | Key-frame request |
| cfg_gop_len | input | 10 | Group length, 0 to 1000 |
| cfg_num_b | input | 3 | B pictures between anchors, 0 to 4 |
| cfg_mode | input | 2 | 0 I-B-P, 1 all-B anchors, 2 low-delay P, 3 low-delay B |
| cfg_idr_period | input | 10 | Frames between periodic IDRs, 0 = off |
| ftype_valid | output | 1 | Picture type valid for the last strobed frame |
| ftype | output | 2 | Picture-type code |
| gop_start | output | 1 | Frame opens a group |
| cfg_invalid | output | 1 | Configuration inputs break a rule |

## Verification
Three sources can fall on the same frame: a key-frame request, the periodic IDR deadline and the natural end of a group. The bench provokes these overlaps in two ways:
- it raises `idr_req` in the very cycle of a strobe;
- it sets an IDR period shorter and longer than the group length, so that the two counters cross.

In every overlap the frame must come out as a single IDR with `gop_start` high, and the counting that follows must restart from it. The bench judges each frame against an arithmetic model built on positions and remainders.

// File: rtl/gop_type_seq.sv
module gop_type_seq #(
  parameter int LEN_W   = 10,
  parameter int B_W     = 3,
  parameter int MAX_LEN = 1000,
  parameter int MAX_B   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             idr_req,
  input  logic [LEN_W-1:0] cfg_gop_len,
  input  logic [B_W-1:0]   cfg_num_b,
  input  logic [1:0]       cfg_mode,
  input  logic [LEN_W-1:0] cfg_idr_period,
  output logic             ftype_valid,
  output logic [1:0]       ftype,
  output logic             gop_start,
  output logic             cfg_invalid
);
  localparam logic [LEN_W-1:0] LIM_L = LEN_W'(MAX_LEN);
  localparam logic [B_W-1:0]   LIM_B = B_W'(MAX_B);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
  localparam logic [1:0] T_IDR = 2'd0, T_I = 2'd1, T_P = 2'd2, T_B = 2'd3;

  logic [LEN_W-1:0] a_len, a_per, pos, icnt;
  logic [B_W-1:0]   a_nb, sub, nb_new;
  logic [1:0]       a_mode, kind;
  logic             first, pend, div_ok;
  logic             per_hit, take_idr, wrap, gstart, adopt;

  always_comb begin
    div_ok = 1'b0;
    for (int k = 0; k <= MAX_B; k++)
      if (cfg_num_b == B_W'(k))
        div_ok = ((32'(cfg_gop_len) % (k + 1)) == 0);
  end

  assign cfg_invalid = (cfg_num_b > LIM_B) || (cfg_gop_len > LIM_L) ||
                       (cfg_idr_period > LIM_L) ||
                       ((cfg_gop_len > ONE_L) && !div_ok);

  assign per_hit  = (a_per != '0) && (icnt == a_per);
  assign take_idr = first | idr_req | pend | per_hit;
  assign wrap     = (a_len <= ONE_L) | (pos == a_len);
  assign gstart   = take_idr | wrap;
  assign adopt    = gstart & ~cfg_invalid;
  assign nb_new   = adopt ? cfg_num_b : a_nb;

  always_comb begin
    if (take_idr)  kind = T_IDR;
    else if (wrap) kind = T_I;
    else begin
      case (a_mode)
        2'd0:    kind = (sub == '0) ? T_P : T_B;
        2'd2:    kind = T_P;
        default: kind = T_B;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_len <= '0; a_per <= '0; a_nb <= '0; a_mode <= 2'd0;
      pos <= '0; sub <= '0; icnt <= '0;
      first <= 1'b1; pend <= 1'b0;
      ftype_valid <= 1'b0; ftype <= T_IDR; gop_start <= 1'b0;
    end else begin
      ftype_valid <= frame_start;
      gop_start   <= frame_start & gstart;
      if (frame_start) begin
        ftype <= kind;
        first <= 1'b0;
        pend  <= 1'b0;
        if (adopt) begin
          a_len <= cfg_gop_len; a_per <= cfg_idr_period;
          a_nb <= cfg_num_b; a_mode <= cfg_mode;
        end
        if (gstart) begin
          pos <= ONE_L;
          sub <= (nb_new == '0) ? '0 : B_W'(1);
        end else begin
          pos <= pos + ONE_L;
          sub <= (sub == a_nb) ? '0 : sub + B_W'(1);
        end
        if (take_idr)        icnt <= ONE_L;
        else if (icnt != '1) icnt <= icnt + ONE_L;
      end else if (idr_req) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gop_type_seq_chk.sv
module gop_type_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       idr_req,
  input logic       ftype_valid,
  input logic [1:0] ftype,
  input logic       gop_start
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ftype_valid);
  assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> !ftype_valid);
  assert_marker_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ftype_valid |-> !gop_start);
  assert_key_opens_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ftype_valid && ftype == 2'd0) |-> gop_start);
  assert_inter_not_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ftype_valid && ftype[1]) |-> !gop_start);
  assert_same_cycle_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && idr_req) |=> (ftype == 2'd0 && gop_start));
endmodule

bind gop_type_seq gop_type_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .idr_req(idr_req),
  .ftype_valid(ftype_valid), .ftype(ftype), .gop_start(gop_start)
);

// File: tb/gop_type_seq_tb.sv
module gop_type_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, idr_req = 1'b0;
  logic [9:0] cfg_gop_len = '0, cfg_idr_period = '0;
  logic [2:0] cfg_num_b = '0;
  logic [1:0] cfg_mode = '0;
  logic ftype_valid, gop_start, cfg_invalid;
  logic [1:0] ftype;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int m_len, m_nb, m_mode, m_per, m_pos, m_icnt;
  bit m_first, m_pend;

  always #4 clk = ~clk;

  gop_type_seq u_dut (.*);

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit bad_cfg();
    int l = cfg_gop_len, b = cfg_num_b;
    return b > 4 || l > 1000 || cfg_idr_period > 1000 || (l >= 2 && (l % (b + 1)) != 0);
  endfunction

  task automatic do_reset();
    rst_n = 0; frame_start = 0; idr_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_len = 0; m_nb = 0; m_mode = 0; m_per = 0; m_pos = 0; m_icnt = 0;
    m_first = 1; m_pend = 0;
  endtask

  task automatic do_frame(string tag, bit req);
    bit idr, wrap;
    int e;
    idr  = m_first || req || m_pend || (m_per != 0 && m_icnt == m_per);
    wrap = (m_len < 2) || (m_pos == m_len);
    if (idr) e = 0;
    else if (wrap) e = 1;
    else if (m_mode == 0) e = ((m_pos % (m_nb + 1)) == 0) ? 2 : 3;
    else if (m_mode == 2) e = 2;
    else e = 3;
    if (idr || wrap) begin
      if (!bad_cfg()) begin
        m_len = cfg_gop_len; m_nb = cfg_num_b; m_mode = cfg_mode; m_per = cfg_idr_period;
      end
      m_pos = 1;
    end else m_pos++;
    m_icnt = idr ? 1 : (m_icnt < 1023 ? m_icnt + 1 : m_icnt);
    m_first = 0; m_pend = 0;
    frame_start = 1; idr_req = req;
    @(negedge clk);
    frame_start = 0; idr_req = 0;
    check({tag, " R1 valid"}, ftype_valid, 1);
    check({tag, " type"}, ftype, e);
    check({tag, " gop_start"}, gop_start, (idr || wrap) ? 1 : 0);
    @(negedge clk);
    check("R1 idle valid", ftype_valid, 0);
  endtask

  task automatic req_between();
    idr_req = 1; @(negedge clk); idr_req = 0;
    check("R10 no output on request", ftype_valid, 0);
    m_pend = 1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset valid", ftype_valid, 0);
    check("R1 reset gop_start", gop_start, 0);

    cfg_gop_len = 0; cfg_num_b = 0; cfg_mode = 0;
    do_frame("R2 first", 0);
    for (int i = 0; i < 4; i++) do_frame("R3 len0", 0);
    cfg_gop_len = 1;
    for (int i = 0; i < 3; i++) do_frame("R3 len1", 0);

    for (int md = 0; md < 4; md++)
      for (int b = 0; b <= 4; b++) begin
        cfg_mode = 2'(md); cfg_num_b = 3'(b); cfg_gop_len = 10'((b + 1) * 3);
        cfg_idr_period = 0;
        do_reset();
        for (int f = 0; f < 2 * (b + 1) * 3 + 2; f++)
          do_frame(md == 0 ? "R4 sweep" : "R5 sweep", 0);
      end

    cfg_gop_len = 7; cfg_num_b = 1; #1;
    check("R6 indivisible", cfg_invalid, 1);
    cfg_gop_len = 6; cfg_num_b = 5; #1;
    check("R6 too many B", cfg_invalid, 1);
    cfg_gop_len = 1001; cfg_num_b = 0; #1;
    check("R6 long group", cfg_invalid, 1);
    cfg_gop_len = 6; cfg_num_b = 2; cfg_idr_period = 1001; #1;
    check("R6 long period", cfg_invalid, 1);
    cfg_idr_period = 0; #1;
    check("R6 valid", cfg_invalid, 0);

    cfg_gop_len = 4; cfg_num_b = 1; cfg_mode = 0;
    do_reset();
    do_frame("R6 run", 0); do_frame("R6 run", 0);
    cfg_gop_len = 7; cfg_mode = 2;
    for (int f = 0; f < 7; f++) do_frame("R6 keep old", 0);

    cfg_gop_len = 6; cfg_num_b = 0; cfg_mode = 0;
    do_reset();
    do_frame("R7 run", 0); do_frame("R7 run", 0);
    cfg_mode = 3;
    for (int f = 0; f < 9; f++) do_frame("R7 deferred", 0);

    cfg_gop_len = 4; cfg_num_b = 0; cfg_mode = 2; cfg_idr_period = 3;
    do_reset();
    for (int f = 0; f < 10; f++) do_frame("R8 short period", 0);
    cfg_idr_period = 6;
    do_reset();
    for (int f = 0; f < 14; f++) do_frame("R8 long period", 0);

    cfg_gop_len = 6; cfg_num_b = 1; cfg_mode = 0; cfg_idr_period = 0;
    do_reset();
    do_frame("R9 run", 0); do_frame("R9 run", 0); do_frame("R9 run", 0);
    do_frame("R9 same cycle", 1);
    for (int f = 0; f < 7; f++) do_frame("R9 after", 0);

    do_frame("R10 run", 0);
    req_between(); req_between(); req_between();
    do_frame("R10 held", 0);
    do_frame("R10 single", 0);
    do_frame("R10 single", 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule